// File: doc/BRIEF.md
# Atomic Test-and-Set Bus Sequencer

This block performs an indivisible test-and-set on one memory byte. A single-cycle start request loads the effective address. The block then runs five microcycles on a simple bus, all at that address. The first two microcycles read the byte. The third is an internal processing step. The last two write the byte back with its most significant bit forced to one. A lock output covers all five microcycles, so no other master can reach memory between the read and the write.

The block takes its condition flags from the byte as it was read. Negative is the byte's top bit and zero is set when the byte is all zeros. Overflow and carry are always cleared. A one-cycle done pulse follows the final write. The data bus is two byte lanes wide. The address's lowest bit chooses the lane.

Top module: `tas_seq_top`

## Requirements
- R1: When idle, a high `start_i` at a clock edge begins the sequence. In the next cycle microcycle one is presented: `bus_addr_o` equals the loaded address, `bus_rd_o`=1, `bus_data_o`=1, `bus_same_o`=0 and both byte strobes are 0.
- R2: Each of microcycles one, two, four and five holds its outputs until `ack_i` is high at a clock edge. `ack_i` has no effect while the block is idle.
- R3: Microcycle two has `bus_rd_o`=1, `bus_data_o`=1, `bus_same_o`=1 and exactly one byte strobe. When address bit 0 is 0, `bus_bhi_o` is the strobe and the byte is taken from `bus_rdata_i[15:8]`. When address bit 0 is 1, `bus_blo_o` is the strobe and the byte is taken from bits [7:0].
- R4: Microcycle three lasts exactly one cycle, whatever `ack_i` does. During it `bus_rd_o`=0, `bus_data_o`=0, `bus_same_o`=1 and no byte strobe is active.
- R5: Microcycles four and five have `bus_rd_o`=0, `bus_data_o`=1 and `bus_same_o`=1. `bus_wdata_o` carries the read byte ORed with 0x80 on both lanes. Only microcycle five asserts the lane strobe chosen as in R3. `bus_wdata_o` is zero outside these two microcycles.
- R6: `bus_addr_o` keeps the loaded address from microcycle one through microcycle five. It is zero when `lock_o` is low.
- R7: `lock_o` is high during microcycles one to five and low at every other time.
- R8: `done_o` is high for exactly the one cycle after microcycle five is acknowledged. `busy_o` is high from microcycle one through that done cycle. A start request made while busy is ignored and does not change the address.
- R9: From the done cycle onward, `flag_n_o` equals bit 7 of the read byte and `flag_z_o` is 1 exactly when the read byte is zero. `flag_v_o` and `flag_c_o` are 0. The flags keep these values until the next operation updates them.
- R10: During reset and after it, before any start, the block is idle. All bus outputs, `lock_o`, `busy_o`, `done_o` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled only when idle |
| ea_i | input | ADDR_W | Effective byte address of the operand |
| ack_i | input | 1 | Data acknowledge that ends a data microcycle |
| bus_rdata_i | input | 2*LANE_W | Read data, two byte lanes |
| bus_addr_o | output | ADDR_W | Bus address, held while locked |
| bus_rd_o | output | 1 | High for read microcycles |
| bus_data_o | output | 1 | Qualifies the microcycle as a data transfer |
| bus_same_o | output | 1 | Address repeats the previous microcycle's address |
| bus_bhi_o | output | 1 | Upper-lane byte strobe (even address) |
| bus_blo_o | output | 1 | Lower-lane byte strobe (odd address) |
| bus_wdata_o | output | 2*LANE_W | Write data, modified byte on both lanes |
| lock_o | output | 1 | Bus lock across the whole sequence |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The bench aims at the bytes whose top bit or zero test sits on a boundary: 0x00, 0x7F, 0x80 and 0xFF, at both even and odd addresses. It checks them against flags and write values computed by its own functions. A design that tested the byte after setting bit 7 would never report zero and would always report negative. A design with the lanes swapped would read junk from the other lane and strobe the wrong lane.

Random acknowledge delays, including none, exercise the stall logic. A sequencer that skipped a wait or stepped through the processing phase on an acknowledge would show the wrong qualifiers in the cycle the bench samples. A new start request is injected mid-sequence. A design that honoured it would move the address while the bus is locked.

// File: rtl/tas_seq_pkg.sv
// Package: shared phase encoding and bus qualifier decode for the
// test-and-set sequencer. Assumes one operation in flight at a time.
package tas_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_RD_ADDR = 3'd1,
        PH_RD_BYTE = 3'd2,
        PH_PROC    = 3'd3,
        PH_WR_DATA = 3'd4,
        PH_WR_BYTE = 3'd5,
        PH_DONE    = 3'd6
    } phase_e;

    typedef struct packed {
        logic rd;
        logic data;
        logic same;
        logic bsel;
    } qual_t;

    // True for phases that stall until the data acknowledge
    function automatic logic waits_ack(phase_e p);
        return (p == PH_RD_ADDR) || (p == PH_RD_BYTE) ||
               (p == PH_WR_DATA) || (p == PH_WR_BYTE);
    endfunction

    // True for the phases that hold the bus lock
    function automatic logic holds_lock(phase_e p);
        return (p == PH_RD_ADDR) || (p == PH_RD_BYTE) || (p == PH_PROC) ||
               (p == PH_WR_DATA) || (p == PH_WR_BYTE);
    endfunction

    // Bus qualifiers that each phase presents
    function automatic qual_t phase_qual(phase_e p);
        qual_t q;
        q = '0;
        case (p)
            PH_RD_ADDR: begin q.rd = 1'b1; q.data = 1'b1; end
            PH_RD_BYTE: begin q.rd = 1'b1; q.data = 1'b1; q.same = 1'b1; q.bsel = 1'b1; end
            PH_PROC:    begin q.same = 1'b1; end
            PH_WR_DATA: begin q.data = 1'b1; q.same = 1'b1; end
            PH_WR_BYTE: begin q.data = 1'b1; q.same = 1'b1; q.bsel = 1'b1; end
            default:    q = '0;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/tas_phase_ctl.sv
// Phase controller: steps through the five locked microcycles, then a
// done cycle. Assumes ack_i is meaningful only in data phases; the
// processing phase always takes exactly one cycle.
module tas_phase_ctl
    import tas_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   ack_i,
    output phase_e phase_o,
    output logic   accept_o,
    output logic   capture_o,
    output logic   flag_upd_o,
    output logic   done_o
);

    phase_e phase_q;
    phase_e phase_d;

    // Next-phase selection
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:    if (start_i) phase_d = PH_RD_ADDR;
            PH_RD_ADDR: if (ack_i)   phase_d = PH_RD_BYTE;
            PH_RD_BYTE: if (ack_i)   phase_d = PH_PROC;
            PH_PROC:                 phase_d = PH_WR_DATA;
            PH_WR_DATA: if (ack_i)   phase_d = PH_WR_BYTE;
            PH_WR_BYTE: if (ack_i)   phase_d = PH_DONE;
            PH_DONE:                 phase_d = PH_IDLE;
            default:                 phase_d = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Control strobes for the datapath
    always_comb begin
        phase_o    = phase_q;
        accept_o   = (phase_q == PH_IDLE) && start_i;
        capture_o  = (phase_q == PH_RD_BYTE) && ack_i;
        flag_upd_o = (phase_q == PH_PROC);
        done_o     = (phase_q == PH_DONE);
    end

    AST_START_ENTERS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && start_i) |=> (phase_q == PH_RD_ADDR)); // R1
    AST_STALL_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (waits_ack(phase_q) && !ack_i) |=> $stable(phase_q)); // R2
    AST_PROC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PROC) |=> (phase_q == PH_WR_DATA)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

endmodule

// File: rtl/tas_addr_hold.sv
// Address holder: captures the effective address on an accepted start
// and keeps it for the whole locked sequence. Assumes load_i only fires
// while idle.
module tas_addr_hold #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              hold_i,
    input  logic [ADDR_W-1:0] ea_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              lane_hi_o
);

    logic [ADDR_W-1:0] addr_q;

    // Address capture register
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (load_i) addr_q <= ea_i;
    end

    // Even byte address maps to the upper lane
    assign lane_hi_o = ~addr_q[0];
    assign addr_o    = addr_q;

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |-> $stable(addr_q)); // R6

endmodule

// File: rtl/tas_byte_unit.sv
// Byte datapath: picks the operand byte from its lane, derives the
// condition flags from the unmodified byte and forms the write-back
// value with the top bit set. Assumes capture_i precedes flag_upd_i.
module tas_byte_unit #(
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture_i,
    input  logic                lane_hi_i,
    input  logic [2*LANE_W-1:0] rdata_i,
    input  logic                flag_upd_i,
    output logic [LANE_W-1:0]   wbyte_o,
    output logic                flag_n_o,
    output logic                flag_z_o,
    output logic                flag_v_o,
    output logic                flag_c_o
);

    localparam int TOP = LANE_W - 1;

    logic [LANE_W-1:0] lane_byte;
    logic [LANE_W-1:0] byte_q;
    logic              n_q, z_q, v_q, c_q;

    // Lane selection for the read byte
    always_comb begin
        lane_byte = lane_hi_i ? rdata_i[2*LANE_W-1:LANE_W] : rdata_i[LANE_W-1:0];
    end

    // Operand byte register
    always_ff @(posedge clk) begin
        if (!rst_n)         byte_q <= '0;
        else if (capture_i) byte_q <= lane_byte;
    end

    // Flag registers, loaded in the processing phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= 1'b0;
            z_q <= 1'b0;
            v_q <= 1'b0;
            c_q <= 1'b0;
        end else if (flag_upd_i) begin
            n_q <= byte_q[TOP];
            z_q <= (byte_q == '0);
            v_q <= 1'b0;
            c_q <= 1'b0;
        end
    end

    // Write-back value with the top bit forced
    always_comb begin
        wbyte_o        = byte_q;
        wbyte_o[TOP]   = 1'b1;
    end

    assign flag_n_o = n_q;
    assign flag_z_o = z_q;
    assign flag_v_o = v_q;
    assign flag_c_o = c_q;

    AST_NEG_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd_i |=> (n_q == $past(byte_q[TOP]))); // R9
    AST_ZERO_NOT_SET_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd_i && byte_q != '0) |=> !z_q); // R9

endmodule

// File: rtl/tas_seq_top.sv
// Test-and-set sequencer top: joins the phase controller, address holder
// and byte datapath, and decodes the bus qualifiers, strobes, lock and
// write data. Assumes a two-lane data bus and one request at a time.
module tas_seq_top
    import tas_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   ea_i,
    input  logic                ack_i,
    input  logic [2*LANE_W-1:0] bus_rdata_i,
    output logic [ADDR_W-1:0]   bus_addr_o,
    output logic                bus_rd_o,
    output logic                bus_data_o,
    output logic                bus_same_o,
    output logic                bus_bhi_o,
    output logic                bus_blo_o,
    output logic [2*LANE_W-1:0] bus_wdata_o,
    output logic                lock_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                flag_n_o,
    output logic                flag_z_o,
    output logic                flag_v_o,
    output logic                flag_c_o
);

    localparam int NLANES = 2;

    phase_e            phase;
    logic              accept, capture, flag_upd, done;
    logic              lane_hi;
    logic              hold;
    logic [ADDR_W-1:0] addr_q;
    logic [LANE_W-1:0] wbyte;
    logic              wr_phase;
    qual_t             q;

    tas_phase_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ack_i      (ack_i),
        .phase_o    (phase),
        .accept_o   (accept),
        .capture_o  (capture),
        .flag_upd_o (flag_upd),
        .done_o     (done)
    );

    // Address must not move in any phase after the first
    assign hold = holds_lock(phase) && (phase != PH_RD_ADDR);

    tas_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .hold_i    (hold),
        .ea_i      (ea_i),
        .addr_o    (addr_q),
        .lane_hi_o (lane_hi)
    );

    tas_byte_unit #(.LANE_W(LANE_W)) u_byte (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (capture),
        .lane_hi_i  (lane_hi),
        .rdata_i    (bus_rdata_i),
        .flag_upd_i (flag_upd),
        .wbyte_o    (wbyte),
        .flag_n_o   (flag_n_o),
        .flag_z_o   (flag_z_o),
        .flag_v_o   (flag_v_o),
        .flag_c_o   (flag_c_o)
    );

    // Bus qualifier, strobe and lock decode
    always_comb begin
        q          = phase_qual(phase);
        lock_o     = holds_lock(phase);
        busy_o     = (phase != PH_IDLE);
        done_o     = done;
        bus_rd_o   = q.rd;
        bus_data_o = q.data;
        bus_same_o = q.same;
        bus_bhi_o  = q.bsel & lane_hi;
        bus_blo_o  = q.bsel & ~lane_hi;
        bus_addr_o = lock_o ? addr_q : '0;
        wr_phase   = (phase == PH_WR_DATA) || (phase == PH_WR_BYTE);
    end

    // Write data replicated on every lane during write phases
    for (genvar g = 0; g < NLANES; g++) begin : g_wlane
        assign bus_wdata_o[g*LANE_W +: LANE_W] = wr_phase ? wbyte : '0;
    end

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_bhi_o, bus_blo_o})); // R3
    AST_WDATA_TOPBIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase |-> (bus_wdata_o[LANE_W-1] && bus_wdata_o[2*LANE_W-1])); // R5
    AST_LOCK_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> done_o); // R7
    AST_NO_LOCK_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o |-> (bus_addr_o == '0)); // R6

endmodule

// File: tb/tas_seq_top_tb.sv
// Bench for the test-and-set sequencer: directed boundary bytes plus
// seeded random operations with random acknowledge delays.
module tas_seq_top_tb_top;

    localparam int ADDR_W = 24;
    localparam int LANE_W = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_i = 1'b0;
    logic [ADDR_W-1:0]   ea_i = '0;
    logic                ack_i = 1'b0;
    logic [2*LANE_W-1:0] bus_rdata_i = '0;
    logic [ADDR_W-1:0]   bus_addr_o;
    logic                bus_rd_o, bus_data_o, bus_same_o, bus_bhi_o, bus_blo_o;
    logic [2*LANE_W-1:0] bus_wdata_o;
    logic                lock_o, busy_o, done_o;
    logic                flag_n_o, flag_z_o, flag_v_o, flag_c_o;

    int checks = 0;
    int fails  = 0;
    bit reported = 1'b0;

    always #10 clk = ~clk;

    tas_seq_top #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ea_i(ea_i), .ack_i(ack_i),
        .bus_rdata_i(bus_rdata_i), .bus_addr_o(bus_addr_o), .bus_rd_o(bus_rd_o),
        .bus_data_o(bus_data_o), .bus_same_o(bus_same_o), .bus_bhi_o(bus_bhi_o),
        .bus_blo_o(bus_blo_o), .bus_wdata_o(bus_wdata_o), .lock_o(lock_o),
        .busy_o(busy_o), .done_o(done_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
        .flag_v_o(flag_v_o), .flag_c_o(flag_c_o)
    );

    function automatic logic exp_neg(logic [7:0] b);
        return b[7];
    endfunction
    function automatic logic exp_zero(logic [7:0] b);
        return (b == 8'h00);
    endfunction
    function automatic logic [7:0] exp_wb(logic [7:0] b);
        return b | 8'h80;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expected qualifiers for phase p (1..5), compared at the ports
    task automatic chk_phase(input int p, input logic [ADDR_W-1:0] a,
                             input logic [7:0] b, input string req);
        logic hi;
        logic bs;
        logic [15:0] wexp;
        hi   = ~a[0];
        bs   = (p == 2) || (p == 5);
        wexp = (p == 4 || p == 5) ? {exp_wb(b), exp_wb(b)} : 16'h0000;
        chk(req, "addr", 32'(bus_addr_o), 32'(a));
        chk(req, "rd", 32'(bus_rd_o), 32'(p <= 2));
        chk(req, "data", 32'(bus_data_o), 32'(p != 3));
        chk(req, "same", 32'(bus_same_o), 32'(p != 1));
        chk(req, "bhi", 32'(bus_bhi_o), 32'(bs & hi));
        chk(req, "blo", 32'(bus_blo_o), 32'(bs & ~hi));
        chk(req, "wdata", 32'(bus_wdata_o), 32'(wexp));
        chk("R7", "lock", 32'(lock_o), 32'd1);
        chk("R8", "busy/done", 32'({busy_o, done_o}), 32'b10);
    endtask

    task automatic run_op(input logic [ADDR_W-1:0] a, input logic [7:0] b,
                          input int maxwait, input bit poke);
        string req;
        start_i = 1'b1;
        ea_i    = a;
        step();
        start_i = 1'b0;
        ea_i    = $urandom;
        for (int p = 1; p <= 5; p++) begin
            req = (p == 1) ? "R1" : (p == 2) ? "R3" : (p == 3) ? "R4" : "R5";
            chk_phase(p, a, b, req);
            if (p == 3) begin
                if (poke) begin
                    start_i = 1'b1;
                    ea_i    = ~a;
                end
                ack_i = 1'($urandom);
                step();
                start_i = 1'b0;
                ack_i   = 1'b0;
            end else begin
                for (int w = $urandom % (maxwait + 1); w > 0; w--) begin
                    step();
                    chk_phase(p, a, b, "R2");
                end
                ack_i = 1'b1;
                if (p == 2) begin
                    if (~a[0]) bus_rdata_i = {b, 8'($urandom)};
                    else       bus_rdata_i = {8'($urandom), b};
                end
                step();
                ack_i       = 1'b0;
                bus_rdata_i = 16'($urandom);
            end
        end
        chk("R8", "done pulse", 32'({done_o, busy_o}), 32'b11);
        chk("R7", "lock after", 32'(lock_o), 32'd0);
        chk("R6", "addr unlocked", 32'(bus_addr_o), 32'd0);
        chk("R9", "flags", 32'({flag_n_o, flag_z_o, flag_v_o, flag_c_o}),
            32'({exp_neg(b), exp_zero(b), 2'b00}));
        step();
        chk("R8", "done cleared", 32'({done_o, busy_o}), 32'b00);
        chk("R9", "flags held", 32'({flag_n_o, flag_z_o, flag_v_o, flag_c_o}),
            32'({exp_neg(b), exp_zero(b), 2'b00}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!reported) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "reset outputs", 32'({bus_rd_o, bus_data_o, bus_same_o, bus_bhi_o,
            bus_blo_o, lock_o, busy_o, done_o}), 32'd0);
        chk("R10", "reset addr/wdata", 32'({bus_addr_o, bus_wdata_o}), 32'd0);
        chk("R10", "reset flags", 32'({flag_n_o, flag_z_o, flag_v_o, flag_c_o}), 32'd0);
        rst_n = 1'b1;
        step();
        chk("R10", "idle after reset", 32'({lock_o, busy_o, done_o}), 32'd0);
        // Acknowledge while idle must not start anything
        ack_i = 1'b1;
        repeat (3) begin
            step();
            chk("R2", "idle ack", 32'({lock_o, busy_o, bus_data_o}), 32'd0);
        end
        ack_i = 1'b0;
        // Directed boundary bytes at even and odd addresses
        run_op(24'h000100, 8'h00, 0, 1'b0);
        run_op(24'h000101, 8'h00, 2, 1'b1);
        run_op(24'h000202, 8'h80, 0, 1'b0);
        run_op(24'h000203, 8'h7F, 1, 1'b1);
        run_op(24'hFFFFFF, 8'hFF, 3, 1'b0);
        run_op(24'hFFFFFE, 8'h01, 0, 1'b1);
        // Seeded random operations
        for (int i = 0; i < 300; i++) begin
            run_op(24'($urandom), 8'($urandom), 4, 1'($urandom));
        end
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
        $finish;
    end

endmodule